// File: doc/BRIEF.md
# Radix-2 Signed-Digit Carry-Free Adder

This block adds two numbers held in radix-2 signed-digit form, where every digit is -1, 0 or +1 and sits on a pair of binary wires. It returns the sum in the same redundant form. Each digit position decides its outgoing transfer and its interim digit from its own digit pair and the pair one position below. The transfer therefore moves at most one position, and the adder's logic depth is the same at any width.

Operands can enter the block in two ways. They can arrive already in encoded signed-digit form. They can also arrive as a magnitude with a sign bit, and the block turns that into digits itself. A subtract control flips every digit of the second operand. The transfer that leaves the top digit is reported as an overflow digit. In the default build, the prepared operands are captured on an input-valid strobe, and the sum and overflow appear one clock later. A parameter can instead make the block purely combinational.

Top module: `sd_carryfree_adder`

## Requirements
- R1: A digit is coded as 2'b01 for +1, 2'b00 for 0 and 2'b10 for -1. An input digit coded 2'b11 is read as 0. No digit of `sum_sd` and no value of `ovf_d` is ever 2'b11.
- R2: The value of `sum_sd` plus the value of `ovf_d` times 2^N equals the value of the prepared first operand plus the value of the prepared second operand. Digit i of `sum_sd` is bits [2i+1:2i] and has weight 2^i.
- R3: Let the position sum p_i be the sum of the two operand digits at position i, with p_-1 taken as 0. The transfer t_i and the interim digit u_i are chosen as follows:
  - p=2 gives t=1, u=0.
  - p=0 gives t=0, u=0.
  - p=-2 gives t=-1, u=0.
  - p=1 with p_(i-1)≥1 gives t=1, u=-1.
  - p=1 with p_(i-1)<1 gives t=0, u=1.
  - p=-1 with p_(i-1)≥1 gives t=0, u=-1.
  - p=-1 with p_(i-1)<1 gives t=-1, u=1.
  
  Each result digit is u_i plus t_(i-1), with t_-1 = 0.
- R4: `ovf_d` carries the transfer t_(N-1) out of the top digit, coded as in R1.
- R5: When `use_mag` is 1, each 1 bit of a magnitude becomes digit +1, or digit -1 if that operand's negative flag is set, and each 0 bit becomes digit 0. When `use_mag` is 0, the encoded digit inputs are used.
- R6: When `sub` is 1, every +1 digit of the prepared second operand becomes -1 and every -1 digit becomes +1, in either input form.
- R7: In the registered build, `out_valid` is 1 exactly in the cycle after a clock edge that saw `in_valid` high. The sum from those operands is presented from that cycle on. A clock edge with `in_valid` low leaves `sum_sd` and `ovf_d` unchanged.
- R8: After reset, `out_valid` is 0, every digit of `sum_sd` is 0 and `ovf_d` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Captures the prepared operands at the clock edge |
| use_mag | input | 1 | 1 selects the magnitude-with-sign inputs, 0 the encoded digit inputs |
| sub | input | 1 | 1 negates the second operand |
| a_sd | input | 2*N | First operand, encoded digits |
| b_sd | input | 2*N | Second operand, encoded digits |
| a_mag | input | N | First operand magnitude |
| a_neg | input | 1 | First operand negative flag |
| b_mag | input | N | Second operand magnitude |
| b_neg | input | 1 | Second operand negative flag |
| sum_sd | output | 2*N | Sum, encoded digits |
| ovf_d | output | 2 | Transfer out of the top digit, encoded |
| out_valid | output | 1 | Sum is from operands captured on the previous edge |

## Verification
The bench builds the block with N=8 in the registered form. At that width, random digit pairs reach every position-sum case of the selection rule. Random operands also drive the top transfer to +1, 0 and -1 often, so overflow is exercised in both directions. Magnitude inputs can be filled with all ones at this width. Directed uniform-digit operands pin down the boundary digits at positions 0 and N-1, where the low neighbour and the outgoing transfer are special.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;

  localparam logic [1:0] DIG_POS  = 2'b01;
  localparam logic [1:0] DIG_ZERO = 2'b00;
  localparam logic [1:0] DIG_NEG  = 2'b10;

  // Encoded digit to a small signed value; the unused code reads as zero.
  function automatic logic signed [2:0] dig_val(input logic [1:0] code);
    logic signed [2:0] v;
    case (code)
      DIG_POS: v = 3'sb001;
      DIG_NEG: v = 3'sb111;
      default: v = 3'sb000;
    endcase
    return v;
  endfunction

  // Small signed value in {-1,0,1} to its code.
  function automatic logic [1:0] dig_enc(input logic signed [2:0] v);
    logic [1:0] code;
    case (v)
      3'sb001: code = DIG_POS;
      3'sb111: code = DIG_NEG;
      default: code = DIG_ZERO;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/sdadd_prep.sv
module sdadd_prep
  import sdadd_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [2*N-1:0] sd_in,
  input  logic [N-1:0]   mag,
  input  logic           neg,
  input  logic           use_mag,
  input  logic           flip,
  output logic [2*N-1:0] dig_out
);

  for (genvar i = 0; i < N; i++) begin : g_dig
    logic [1:0] from_sd;
    logic [1:0] from_mag;
    logic [1:0] picked;

    // Unused code 11 is normalised to zero here so nothing downstream sees it.
    assign from_sd  = (sd_in[2*i +: 2] == 2'b11) ? DIG_ZERO : sd_in[2*i +: 2];
    assign from_mag = mag[i] ? (neg ? DIG_NEG : DIG_POS) : DIG_ZERO;
    assign picked   = use_mag ? from_mag : from_sd;
    // Swapping the two wires negates a legal digit and keeps zero as zero.
    assign dig_out[2*i +: 2] = flip ? {picked[0], picked[1]} : picked;
  end

endmodule

// File: rtl/sdadd_slice.sv
module sdadd_slice
  import sdadd_pkg::*;
(
  input  logic [1:0] x_d,
  input  logic [1:0] y_d,
  input  logic [1:0] x_lo,
  input  logic [1:0] y_lo,
  input  logic [1:0] t_lo,
  output logic [1:0] t_d,
  output logic [1:0] s_d
);

  logic signed [2:0] p_here;
  logic signed [2:0] p_low;
  logic signed [2:0] t_v;
  logic signed [2:0] u_v;
  logic signed [2:0] s_v;
  logic              low_high;

  always_comb begin
    p_here   = dig_val(x_d) + dig_val(y_d);
    p_low    = dig_val(x_lo) + dig_val(y_lo);
    low_high = (p_low >= 3'sb001);
    t_v      = 3'sb000;
    u_v      = 3'sb000;
    case (p_here)
      3'sb010: begin t_v = 3'sb001; u_v = 3'sb000; end
      3'sb001: begin
        if (low_high) begin t_v = 3'sb001; u_v = 3'sb111; end
        else          begin t_v = 3'sb000; u_v = 3'sb001; end
      end
      3'sb111: begin
        if (low_high) begin t_v = 3'sb000; u_v = 3'sb111; end
        else          begin t_v = 3'sb111; u_v = 3'sb001; end
      end
      3'sb110: begin t_v = 3'sb111; u_v = 3'sb000; end
      default: begin t_v = 3'sb000; u_v = 3'sb000; end
    endcase
    s_v = u_v + dig_val(t_lo);
    t_d = dig_enc(t_v);
    s_d = dig_enc(s_v);
  end

  // R3: transfer and interim digit always split the position sum exactly.
  always_comb begin
    if (!$isunknown({x_d, y_d, x_lo, y_lo, t_lo})) begin
      a_r3_split_exact: assert ((t_v <<< 1) + u_v == p_here);
      // R1: the incoming transfer never pushes a result digit out of range.
      a_r1_digit_range: assert (s_v >= 3'sb111 && s_v <= 3'sb001);
    end
  end

endmodule

// File: rtl/sdadd_array.sv
module sdadd_array
  import sdadd_pkg::*;
#(
  parameter int N = 64
) (
  input  logic [2*N-1:0] x_sd,
  input  logic [2*N-1:0] y_sd,
  output logic [2*N-1:0] s_sd,
  output logic [1:0]     top_t
);

  localparam int EW = 2*N + 2;

  logic [EW-1:0] x_ext;
  logic [EW-1:0] y_ext;
  logic [EW-1:0] t_chain;

  // Position -1 is a zero digit pair with a zero transfer.
  assign x_ext          = {x_sd, DIG_ZERO};
  assign y_ext          = {y_sd, DIG_ZERO};
  assign t_chain[1:0]   = DIG_ZERO;

  for (genvar i = 0; i < N; i++) begin : g_pos
    sdadd_slice u_slice (
      .x_d  (x_ext[2*i+2 +: 2]),
      .y_d  (y_ext[2*i+2 +: 2]),
      .x_lo (x_ext[2*i +: 2]),
      .y_lo (y_ext[2*i +: 2]),
      .t_lo (t_chain[2*i +: 2]),
      .t_d  (t_chain[2*i+2 +: 2]),
      .s_d  (s_sd[2*i +: 2])
    );
  end

  assign top_t = t_chain[EW-1 -: 2];

endmodule

// File: rtl/sd_carryfree_adder.sv
module sd_carryfree_adder
  import sdadd_pkg::*;
#(
  parameter int N          = 64,
  parameter bit REGISTERED = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           use_mag,
  input  logic           sub,
  input  logic [2*N-1:0] a_sd,
  input  logic [2*N-1:0] b_sd,
  input  logic [N-1:0]   a_mag,
  input  logic           a_neg,
  input  logic [N-1:0]   b_mag,
  input  logic           b_neg,
  output logic [2*N-1:0] sum_sd,
  output logic [1:0]     ovf_d,
  output logic           out_valid
);

  localparam int DW = 2*N;
  localparam int VW = N + 3;

  logic [DW-1:0] a_prep;
  logic [DW-1:0] b_prep;
  logic [DW-1:0] a_use;
  logic [DW-1:0] b_use;

  sdadd_prep #(.N(N)) u_prep_a (
    .sd_in   (a_sd),
    .mag     (a_mag),
    .neg     (a_neg),
    .use_mag (use_mag),
    .flip    (1'b0),
    .dig_out (a_prep)
  );

  sdadd_prep #(.N(N)) u_prep_b (
    .sd_in   (b_sd),
    .mag     (b_mag),
    .neg     (b_neg),
    .use_mag (use_mag),
    .flip    (sub),
    .dig_out (b_prep)
  );

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  if (REGISTERED) begin : g_reg
    logic [DW-1:0] a_q, a_nxt;
    logic [DW-1:0] b_q, b_nxt;
    logic          vld_q, vld_nxt;

    always_comb begin
      a_nxt   = a_q;
      b_nxt   = b_q;
      vld_nxt = in_valid;
      if (in_valid) begin
        a_nxt = a_prep;
        b_nxt = b_prep;
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        a_q   <= '0;
        b_q   <= '0;
        vld_q <= 1'b0;
      end else begin
        a_q   <= a_nxt;
        b_q   <= b_nxt;
        vld_q <= vld_nxt;
      end
    end

    assign a_use     = a_q;
    assign b_use     = b_q;
    assign out_valid = vld_q;
  end else begin : g_comb
    assign a_use     = a_prep;
    assign b_use     = b_prep;
    assign out_valid = in_valid;
  end

  sdadd_array #(.N(N)) u_array (
    .x_sd  (a_use),
    .y_sd  (b_use),
    .s_sd  (sum_sd),
    .top_t (ovf_d)
  );

  // ---------------------------------------------------------------
  // Checks
  function automatic logic signed [VW-1:0] sd_value(input logic [DW-1:0] v);
    logic signed [VW-1:0] acc;
    acc = '0;
    for (int i = N - 1; i >= 0; i--) begin
      acc = acc <<< 1;
      if (v[2*i +: 2] == DIG_POS)      acc = acc + VW'(1);
      else if (v[2*i +: 2] == DIG_NEG) acc = acc - VW'(1);
    end
    return acc;
  endfunction

  function automatic logic no_bad_code(input logic [DW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N; i++)
      if (v[2*i +: 2] == 2'b11) ok = 1'b0;
    return ok;
  endfunction

  logic signed [VW-1:0] top_weight;
  assign top_weight = (ovf_d == DIG_POS) ? (VW'(1) <<< N) :
                      (ovf_d == DIG_NEG) ? -(VW'(1) <<< N) : '0;

  // R1: no illegal code leaves the block.
  a_r1_no_bad_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    no_bad_code(sum_sd) && ovf_d != 2'b11);

  // R2 / R4: sum plus weighted top transfer equals operand sum.
  a_r2_value_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sd_value(sum_sd) + top_weight == sd_value(a_use) + sd_value(b_use));

  if (REGISTERED) begin : g_reg_chk
    // R7: valid follows the strobe by one cycle.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
      in_valid |=> out_valid);
    a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !in_valid |=> !out_valid);
    // R7: an idle edge leaves the result alone.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !in_valid |=> ($stable(sum_sd) && $stable(ovf_d)));
  end

endmodule

// File: tb/test_sd_carryfree_adder.sv
module test_sd_carryfree_adder;

  localparam int N       = 8;
  localparam int DW      = 2*N;
  localparam int CLK_PER = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, use_mag, sub, a_neg, b_neg;
  logic [DW-1:0] a_sd, b_sd;
  logic [N-1:0]  a_mag, b_mag;
  logic [DW-1:0] sum_sd;
  logic [1:0]    ovf_d;
  logic          out_valid;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  sd_carryfree_adder #(.N(N), .REGISTERED(1'b1)) i_sd_carryfree_adder (
    .clk, .rst_n, .in_valid, .use_mag, .sub, .a_sd, .b_sd,
    .a_mag, .a_neg, .b_mag, .b_neg, .sum_sd, .ovf_d, .out_valid
  );

  function automatic int dv(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? -1 : 0;
  endfunction

  function automatic logic [1:0] de(input int v);
    return (v == 1) ? 2'b01 : (v == -1) ? 2'b10 : 2'b00;
  endfunction

  // R5/R6 operand preparation, from the requirements.
  function automatic logic [DW-1:0] prep(input logic [DW-1:0] sd, input logic [N-1:0] m,
                                         input bit ng, input bit um, input bit fl);
    logic [DW-1:0] r;
    for (int i = 0; i < N; i++) begin
      int v;
      v = um ? (m[i] ? (ng ? -1 : 1) : 0) : dv(sd[2*i +: 2]);
      if (fl) v = -v;
      r[2*i +: 2] = de(v);
    end
    return r;
  endfunction

  // R3/R4 digit selection rule; returns {top transfer, sum digits}.
  function automatic logic [DW+1:0] ref_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    int p [N];
    int t [N];
    int u [N];
    logic [DW+1:0] r;
    for (int i = 0; i < N; i++) p[i] = dv(a[2*i +: 2]) + dv(b[2*i +: 2]);
    for (int i = 0; i < N; i++) begin
      int pl;
      pl = (i == 0) ? 0 : p[i-1];
      case (p[i])
        2:  begin t[i] = 1;  u[i] = 0; end
        1:  if (pl >= 1) begin t[i] = 1; u[i] = -1; end else begin t[i] = 0; u[i] = 1; end
        -1: if (pl >= 1) begin t[i] = 0; u[i] = -1; end else begin t[i] = -1; u[i] = 1; end
        -2: begin t[i] = -1; u[i] = 0; end
        default: begin t[i] = 0; u[i] = 0; end
      endcase
    end
    for (int i = 0; i < N; i++) r[2*i +: 2] = de(u[i] + ((i == 0) ? 0 : t[i-1]));
    r[DW +: 2] = de(t[N-1]);
    return r;
  endfunction

  function automatic longint bval(input logic [DW-1:0] v);
    longint acc = 0;
    for (int i = N - 1; i >= 0; i--) acc = acc * 2 + dv(v[2*i +: 2]);
    return acc;
  endfunction

  function automatic bit has_bad(input logic [DW-1:0] v);
    for (int i = 0; i < N; i++) if (v[2*i +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one operation and check the result a cycle later.
  task automatic run_op(input logic [DW-1:0] asd, input logic [DW-1:0] bsd,
                        input logic [N-1:0] am, input bit an,
                        input logic [N-1:0] bm, input bit bn,
                        input bit um, input bit sb, input string tag);
    logic [DW-1:0] pa, pb;
    logic [DW+1:0] exp;
    longint        got_v;
    @(negedge clk);
    a_sd = asd; b_sd = bsd; a_mag = am; a_neg = an; b_mag = bm; b_neg = bn;
    use_mag = um; sub = sb; in_valid = 1'b1;
    pa  = prep(asd, am, an, um, 1'b0);
    pb  = prep(bsd, bm, bn, um, sb);
    exp = ref_add(pa, pb);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {"R7 valid ", tag}, out_valid, 1);
    check({ovf_d, sum_sd} === exp, {"R3 digits ", tag}, {ovf_d, sum_sd}, exp);
    check(ovf_d === exp[DW +: 2], {"R4 top transfer ", tag}, ovf_d, exp[DW +: 2]);
    got_v = bval(sum_sd) + longint'(dv(ovf_d)) * (longint'(1) << N);
    check(got_v == bval(pa) + bval(pb), {"R2 value ", tag}, got_v, bval(pa) + bval(pb));
    check(!has_bad(sum_sd) && ovf_d != 2'b11, {"R1 codes ", tag}, sum_sd, 0);
  endtask

  initial begin
    int seed;
    logic [DW-1:0] held;
    logic [1:0]    held_o;
    seed = $urandom(32'h5D_A11E);
    rst_n = 1'b0; in_valid = 1'b0; use_mag = 1'b0; sub = 1'b0;
    a_sd = '0; b_sd = '0; a_mag = '0; b_mag = '0; a_neg = 1'b0; b_neg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    check(out_valid === 1'b0, "R8 valid low", out_valid, 0);
    check(sum_sd === '0, "R8 sum zero", sum_sd, 0);
    check(ovf_d === 2'b00, "R8 ovf zero", ovf_d, 0);

    // R3 uniform +1 plus zero: p=1 everywhere, top transfer +1
    run_op({N{2'b01}}, '0, '0, 0, '0, 0, 0, 0, "all_plus");
    // R3 uniform -1 plus -1: p=-2 everywhere, top transfer -1
    run_op({N{2'b10}}, {N{2'b10}}, '0, 0, '0, 0, 0, 0, "all_minus");
    // R3 mixed -1 with zero low neighbour
    run_op({N{2'b10}}, '0, '0, 0, '0, 0, 0, 0, "minus_one_col");
    // R1 unused code reads as zero
    run_op({N{2'b11}}, {N{2'b01}}, '0, 0, '0, 0, 0, 0, "code11");
    // R5 magnitudes, signs, full ones
    run_op('0, '0, 8'd5, 1, 8'd3, 0, 1, 0, "mag_mixed");
    run_op('0, '0, 8'hFF, 0, 8'hFF, 0, 1, 0, "mag_full");
    run_op('0, '0, 8'hFF, 1, 8'hFF, 1, 1, 0, "mag_full_neg");
    // R6 subtraction in both forms
    run_op('0, '0, 8'd9, 0, 8'd9, 0, 1, 1, "sub_mag_self");
    run_op({N{2'b01}}, {N{2'b10}}, '0, 0, '0, 0, 0, 1, "sub_sd");

    // R7 idle edge keeps the result
    held = sum_sd; held_o = ovf_d;
    @(negedge clk);
    a_sd = {N{2'b01}}; b_sd = {N{2'b01}}; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R7 valid drops", out_valid, 0);
    check(sum_sd === held && ovf_d === held_o, "R7 hold idle", sum_sd, held);

    // Random mix of all forms
    for (int k = 0; k < 400; k++) begin
      run_op(DW'($urandom), DW'($urandom), N'($urandom), 1'($urandom),
             N'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule